// File: doc/BRIEF.md
# Row-Loaded 8x8 Inverse DCT Engine

This block computes a two-dimensional 8x8 inverse discrete cosine transform. It is meant to sit next to a processor that moves data in 128-bit quadword transfers. Each quadword write carries one row of eight signed 16-bit frequency coefficients. Each quadword read returns one row of eight reconstructed pixels. There is no start command. The horizontal one-dimensional pass runs on each row in the cycle that row is written. Its results go into a 16-bit transpose buffer.

When the eighth row has been accepted, a column sequencer runs the vertical pass. It handles one column per cycle, using the same multiply-accumulate structure. It rounds each result, saturates it to the signed 9-bit pixel range and stores it in an output buffer. Software then issues eight reads, which return the pixel rows in order. A read asked for too early is simply held off. Writes that arrive while results are still waiting to be read are dropped and raise a sticky overrun flag.

Top module: `idct_qw_engine`

## Requirements
- R1: After reset, `busy`, `overrun` and `rd_valid` are 0, even while `rd_req` is held high.
- R2: `busy` rises in the cycle after the first row of a block is accepted. It stays high through loading, computing and reading, and falls in the cycle after the eighth result row has been read.
- R3: A write with `wr_valid` high is accepted in the load phase. Coefficient k of the row (k = 0..7) sits in bits [16k+15:16k] as a two's-complement value. Accepted writes fill rows 0 to 7 in arrival order.
- R4: Both passes use basis values B(k,n) = round(4096 * s(k) * cos((2n+1)k*pi/16)), where s(0) = 1/sqrt(8), s(k>0) = 1/2, and the rounding is half away from zero. Each pass output is (sum + 2048) arithmetically shifted right by 12. The row pass (over the coefficients of one row) is saturated to signed 16 bits. The column pass (over the transposed intermediate column) is then applied.
- R5: Every output pixel is saturated to the range -256..255 and sign-extended to 16 bits. Pixel c of a result row sits in bits [16c+15:16c].
- R6: `rd_valid` can first be high exactly 8 cycles after the clock edge that accepts the eighth row, which is one cycle per column.
- R7: `rd_valid` is high only when `rd_req` is high and a computed result row is waiting. A read request during loading or computing gets `rd_valid` low.
- R8: Each cycle with `rd_req` and `rd_valid` both high delivers the next result row, rows 0 to 7 in order. Dropping `rd_req` pauses the sequence without losing a row.
- R9: A write that arrives while computing or while result rows are unread is ignored: the results read out are unchanged. It sets `overrun`, which stays high until reset.
- R10: After the eighth read, a new block is accepted. Rows may arrive back to back or with any idle spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Quadword row write strobe |
| wr_data | input | 128 | Eight signed 16-bit coefficients of one row |
| rd_req | input | 1 | Request for the next result row |
| rd_valid | output | 1 | Result row on `rd_data` is delivered this cycle |
| rd_data | output | 128 | Eight sign-extended pixels of the current result row |
| busy | output | 1 | A block is loading, computing or waiting to be read |
| overrun | output | 1 | Sticky flag: a write was dropped |

## Verification
The embedded properties assume that `wr_valid` and `rd_req` are known, 0 or 1, at every edge after reset. They also assume the reader may lower `rd_req` at any cycle, so that a read counts only on a cycle where both `rd_req` and `rd_valid` are high. To keep within these assumptions, the stimulus changes all inputs 2 ns after the rising edge. It toggles `rd_req` on some blocks and writes unrelated data only while results are pending, in order to exercise the drop rule. The coefficient patterns cover a small DC value, random 12-bit data, full-scale values that drive both saturation limits, and isolated AC terms.

// File: rtl/idct_pkg.sv
package idct_pkg;
    localparam int N       = 8;
    localparam int WW      = 16;
    localparam int QW      = N * WW;
    localparam int IW      = $clog2(N);
    localparam int FRAC    = 12;
    localparam int AW      = WW + FRAC + 6;
    localparam int MID_MIN = -(1 << (WW - 1));
    localparam int MID_MAX = (1 << (WW - 1)) - 1;
    localparam int PIX_MIN = -256;
    localparam int PIX_MAX = 255;
    localparam int DC_GAIN = 1448;

    typedef logic signed [WW-1:0] elem_t;
    typedef elem_t [N-1:0]        vec_t;
    typedef logic signed [AW-1:0] acc_t;
    typedef acc_t [N-1:0]         accv_t;
    typedef enum logic [1:0] {PH_LOAD, PH_COLS, PH_DRAIN} phase_e;

    // Scaled cosine basis value for frequency k at sample n.
    function automatic int basis(input int k, input int n);
        int  m;
        int  mag;
        bit  neg;
        if (k == 0) return DC_GAIN;
        m = ((2 * n + 1) * k) % 32;
        if (m > 16) m = 32 - m;
        neg = (m > 8);
        if (neg) m = 16 - m;
        case (m)
            0:       mag = 2048;
            1:       mag = 2009;
            2:       mag = 1892;
            3:       mag = 1703;
            4:       mag = 1448;
            5:       mag = 1138;
            6:       mag = 784;
            7:       mag = 400;
            default: mag = 0;
        endcase
        return neg ? -mag : mag;
    endfunction

    // Round half up, drop the fraction, clamp into [lo, hi].
    function automatic elem_t descale(input acc_t s, input int lo, input int hi);
        acc_t r;
        r = (s + acc_t'(1 << (FRAC - 1))) >>> FRAC;
        if (r < acc_t'(lo)) return elem_t'(lo);
        if (r > acc_t'(hi)) return elem_t'(hi);
        return elem_t'(r);
    endfunction
endpackage

// File: rtl/idct_1d.sv
module idct_1d
    import idct_pkg::*;
(
    input  vec_t  din,
    output accv_t sum
);
    for (genvar n = 0; n < N; n++) begin : g_tap
        acc_t acc;
        always_comb begin
            acc = '0;
            for (int k = 0; k < N; k++) begin
                acc = acc + acc_t'(din[k]) * acc_t'(basis(k, n));
            end
        end
        assign sum[n] = acc;
    end
endmodule

// File: rtl/idct_ctrl.sv
module idct_ctrl
    import idct_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic          rd_req,
    output logic          row_load,
    output logic          col_step,
    output logic          rd_valid,
    output logic [IW-1:0] row_idx,
    output logic [IW-1:0] col_idx,
    output logic [IW-1:0] rd_idx,
    output logic          busy,
    output logic          overrun
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    phase_e phase;

    assign row_load = wr_valid && (phase == PH_LOAD);
    assign col_step = (phase == PH_COLS);
    assign rd_valid = rd_req && (phase == PH_DRAIN);
    assign busy     = (phase != PH_LOAD) || (row_idx != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_LOAD;
            row_idx <= '0;
            col_idx <= '0;
            rd_idx  <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr_valid && (phase != PH_LOAD)) overrun <= 1'b1;
            case (phase)
                PH_LOAD: if (wr_valid) begin
                    if (row_idx == LAST) begin
                        row_idx <= '0;
                        phase   <= PH_COLS;
                    end else begin
                        row_idx <= row_idx + 1'b1;
                    end
                end
                PH_COLS: begin
                    if (col_idx == LAST) begin
                        col_idx <= '0;
                        phase   <= PH_DRAIN;
                    end else begin
                        col_idx <= col_idx + 1'b1;
                    end
                end
                PH_DRAIN: if (rd_req) begin
                    if (rd_idx == LAST) begin
                        rd_idx <= '0;
                        phase  <= PH_LOAD;
                    end else begin
                        rd_idx <= rd_idx + 1'b1;
                    end
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !(rd_valid && rd_idx == LAST)) |=> busy);
    p_busy_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_idx == LAST) |=> !busy);
    p_col_span_r6: assert property (@(posedge clk) disable iff (rst)
        (col_step && col_idx == LAST) |=> (phase == PH_DRAIN));
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
    p_drop_sets_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !row_load) |=> overrun);
endmodule

// File: rtl/idct_qw_engine.sv
module idct_qw_engine
    import idct_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [QW-1:0] wr_data,
    input  logic          rd_req,
    output logic          rd_valid,
    output logic [QW-1:0] rd_data,
    output logic          busy,
    output logic          overrun
);
    logic          row_load, col_step;
    logic [IW-1:0] row_idx, col_idx, rd_idx;

    vec_t  tbuf [N];
    vec_t  obuf [N];
    vec_t  row_in, row_px, col_in, col_px;
    accv_t row_sum, col_sum;

    idct_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .rd_req   (rd_req),
        .row_load (row_load),
        .col_step (col_step),
        .rd_valid (rd_valid),
        .row_idx  (row_idx),
        .col_idx  (col_idx),
        .rd_idx   (rd_idx),
        .busy     (busy),
        .overrun  (overrun)
    );

    // Horizontal pass on the incoming row.
    assign row_in = vec_t'(wr_data);
    idct_1d u_row (.din(row_in), .sum(row_sum));

    // Vertical pass on the selected transposed column.
    always_comb begin
        for (int r = 0; r < N; r++) begin
            col_in[r] = tbuf[r][col_idx];
        end
    end
    idct_1d u_col (.din(col_in), .sum(col_sum));

    for (genvar i = 0; i < N; i++) begin : g_scale
        assign row_px[i] = descale(row_sum[i], MID_MIN, MID_MAX);
        assign col_px[i] = descale(col_sum[i], PIX_MIN, PIX_MAX);
    end

    always_ff @(posedge clk) begin
        if (row_load) tbuf[row_idx] <= row_px;
        if (col_step) begin
            for (int r = 0; r < N; r++) begin
                obuf[r][col_idx] <= col_px[r];
            end
        end
    end

    assign rd_data = QW'(obuf[rd_idx]);

    logic px_ok;
    always_comb begin
        px_ok = 1'b1;
        for (int c = 0; c < N; c++) begin
            if ($signed(rd_data[c*WW +: WW]) < PIX_MIN || $signed(rd_data[c*WW +: WW]) > PIX_MAX)
                px_ok = 1'b0;
        end
    end

    p_pix_range_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> px_ok);
    p_valid_needs_busy_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);
    p_valid_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_req |-> !rd_valid);
endmodule

// File: tb/sim_idct_qw_engine.sv
module sim_idct_qw_engine;
    import idct_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [QW-1:0] wr_data = '0;
    logic          rd_req = 1'b0;
    logic          rd_valid, busy, overrun;
    logic [QW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int unsigned seed = 32'h1234_5678;

    int blk [8][8];
    logic [QW-1:0] exp_q [$];

    always #10 clk = ~clk;

    idct_qw_engine u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .overrun(overrun)
    );

    task automatic check(input bit ok, input string tag, input logic [QW-1:0] act, input logic [QW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic int ref_coef(input int k, input int n);
        real s, v;
        s = (k == 0) ? 1.0 / $sqrt(8.0) : 0.5;
        v = s * $cos(real'((2 * n + 1) * k) * 3.14159265358979 / 16.0) * 4096.0;
        return (v >= 0.0) ? int'($floor(v + 0.5)) : -int'($floor(-v + 0.5));
    endfunction

    function automatic int ref_scale(input longint s, input int lo, input int hi);
        longint r;
        r = (s + 2048) >>> 12;
        if (r < lo) return lo;
        if (r > hi) return hi;
        return int'(r);
    endfunction

    function automatic int rnd12();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hFFF) - 2048;
    endfunction

    task automatic fill(input int pat);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                case (pat)
                    0: blk[r][c] = (r == 0 && c == 0) ? 64 : 0;
                    1: blk[r][c] = rnd12();
                    2: blk[r][c] = 2047;
                    3: blk[r][c] = -2048;
                    4: blk[r][c] = (r == 1 && c == 2) ? 1000 : ((r == 7 && c == 7) ? -1500 : 0);
                    default: blk[r][c] = ((r + c) % 2 == 0) ? 32767 : -32768;
                endcase
            end
    endtask

    // Compute the expected result rows and push them to the scoreboard.
    task automatic predict();
        int t [8][8];
        longint acc;
        logic [QW-1:0] row;
        for (int r = 0; r < 8; r++)
            for (int n = 0; n < 8; n++) begin
                acc = 0;
                for (int k = 0; k < 8; k++) acc += longint'(ref_coef(k, n)) * blk[r][k];
                t[r][n] = ref_scale(acc, -32768, 32767);
            end
        for (int r = 0; r < 8; r++) begin
            row = '0;
            for (int c = 0; c < 8; c++) begin
                acc = 0;
                for (int k = 0; k < 8; k++) acc += longint'(ref_coef(k, r)) * t[k][c];
                row[c*16 +: 16] = 16'(ref_scale(acc, -256, 255));
            end
            exp_q.push_back(row);
        end
    endtask

    // Driver: caller is 2 ns past a rising edge.
    task automatic send_block(input int gap, input bit probe);
        predict();
        for (int r = 0; r < 8; r++) begin
            wr_valid = 1'b1;
            for (int k = 0; k < 8; k++) wr_data[k*16 +: 16] = 16'(blk[r][k]);
            @(posedge clk); #2;
            wr_valid = 1'b0;
            if (r == 0) check(busy == 1'b1, "R2 busy after first row", QW'(busy), QW'(1));
            if (probe && r == 3) begin
                rd_req = 1'b1;
                @(negedge clk);
                check(rd_valid == 1'b0, "R7 read during load", QW'(rd_valid), QW'(0));
                @(posedge clk); #2;
                rd_req = 1'b0;
            end
            for (int g = 0; g < gap; g++) begin @(posedge clk); #2; end
        end
    endtask

    task automatic drain(input bit choppy);
        int i = 0;
        while (exp_q.size() != 0) begin
            rd_req = choppy ? (i % 3 != 2) : 1'b1;
            i++;
            @(posedge clk); #2;
        end
        rd_req = 1'b0;
    endtask

    // Monitor: compare every delivered row against the queue head.
    always @(negedge clk) begin
        if (!rst && rd_valid && rd_req) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected read", rd_data, '0);
            end else begin
                logic [QW-1:0] e;
                e = exp_q.pop_front();
                check(rd_data === e, "R3/R4/R5/R8 result row", rd_data, e);
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        rd_req = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy at reset", QW'(busy), QW'(0));
        check(overrun == 1'b0, "R1 overrun at reset", QW'(overrun), QW'(0));
        check(rd_valid == 1'b0, "R1 rd_valid at reset", QW'(rd_valid), QW'(0));
        @(posedge clk); #2;
        rd_req = 1'b0;

        // Small DC, spaced rows, read probe mid-load.
        fill(0); send_block(2, 1'b1); drain(1'b0);
        check(busy == 1'b0, "R2 busy after eighth read", QW'(busy), QW'(0));

        // Random data back to back; measure the hold-off (R6).
        fill(1); send_block(0, 1'b0);
        rd_req = 1'b1;
        cnt = 0;
        @(negedge clk);
        while (!rd_valid && cnt < 40) begin cnt++; @(negedge clk); end
        check(cnt == 8, "R6 cycles to first valid", QW'(cnt), QW'(8));
        @(posedge clk); #2;
        drain(1'b1);

        // Saturation at both ends (R5).
        fill(2); send_block(1, 1'b0); drain(1'b0);
        fill(3); send_block(0, 1'b0); drain(1'b1);
        check(overrun == 1'b0, "R9 no overrun yet", QW'(overrun), QW'(0));

        // Stray writes during compute and drain are dropped (R9).
        fill(4); send_block(0, 1'b0);
        wr_valid = 1'b1; wr_data = {8{16'h7FFF}};
        repeat (3) begin @(posedge clk); #2; end
        drain(1'b1);
        wr_valid = 1'b0;
        check(overrun == 1'b1, "R9 overrun set", QW'(overrun), QW'(1));
        check(busy == 1'b0, "R9 dropped writes start no block", QW'(busy), QW'(0));

        // Full-scale 16-bit input, wide spacing (R10).
        fill(5); send_block(3, 1'b0); drain(1'b0);
        check(overrun == 1'b1, "R9 overrun sticky", QW'(overrun), QW'(1));
        for (int b = 0; b < 3; b++) begin
            fill(1); send_block(b, 1'b0); drain(b[0]);
        end

        rst = 1'b1;
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        check(overrun == 1'b0, "R9 overrun cleared by reset", QW'(overrun), QW'(0));
        check(exp_q.size() == 0, "R10 all rows delivered", QW'(exp_q.size()), QW'(0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule